// File: doc/BRIEF.md
# Display Format Resolver

This block turns the raw display control words of a video output stage into the framebuffer geometry that a scan-out engine needs. At every frame boundary it samples a size word, a mode word and two configuration words. From them it computes the horizontal and vertical resolution, the colour format code, the row stride in bytes, the output-enable state, and a blank flag with its border colour. All of these are held in registers until the next frame boundary.

The size word counts each line in 32-bit words, not pixels. The block therefore converts that word count to a pixel count for each colour depth. For the three-byte format this means an exact divide by three, done combinationally with a reciprocal multiply. The block also keeps the previous frame's geometry and raises a one-cycle pulse when the resolution or the colour format changes. Downstream logic uses that pulse to reconfigure its pixel pipeline.

Top module: `disp_fmt_resolver`

## Requirements
- R1: After reset every output is zero: resolutions, format code, stride, enable, blank, border colour and the change pulse.
- R2: Outputs change only in the cycle after `frame_tick` is high. Changes to the control words in other cycles have no effect on the outputs.
- R3: Vertical resolution is the lines field (size word bits 19:10) plus one. When the interlace bit (config word bit 4) is set, that value is doubled.
- R4: Colour mode is mode word bits 3:2. For mode 0 and mode 1, horizontal resolution is twice the word count, where the word count is size word bits 9:0 plus one.
- R5: For mode 2, horizontal resolution is floor(word count × 4 / 3), exact for all field values. For mode 3 it equals the word count. The format output carries the mode value.
- R6: Stride in bytes is (word count + modulo − 1) × 4, where modulo is size word bits 29:20.
- R7: The enable output is set only when the display-enable bit (mode word bit 0) and the video-out bit (config word bit 3) are both set.
- R8: When enabled and bit 3 of the second config word is set, the blank output is 1 and the border output carries the border word. Otherwise blank is 0 and border is 0.
- R9: A frame sampled while disabled sets both resolutions to zero and raises no change pulse. The format code and stride keep their old values.
- R10: When an enabled frame's horizontal resolution, vertical resolution or format differs from the values held before, `fmt_changed` is high for exactly the one cycle after the tick.
- R11: A frame that changes only the stride, blank or border, with the same resolution and format, raises no change pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | Frame boundary strobe; control words are sampled on it |
| size_word | input | 32 | Word count, lines and modulo fields |
| mode_word | input | 32 | Display enable (bit 0), colour mode (bits 3:2) |
| cfg_word | input | 32 | Video-out (bit 3), interlace (bit 4) |
| cfg2_word | input | 32 | Blank request (bit 3) |
| border_word | input | 24 | Border colour |
| hres | output | 12 | Resolved horizontal pixels |
| vres | output | 12 | Resolved vertical lines |
| fmt | output | 2 | Colour format code |
| stride | output | 14 | Row stride in bytes |
| enabled | output | 1 | Display output active |
| blank | output | 1 | Frame blanked |
| border | output | 24 | Border colour while blanked |
| fmt_changed | output | 1 | One-cycle reconfiguration pulse |

## Verification
Random frames draw every field across its full range. Sweeping all four colour modes over random word counts separates the doubling path, the pass-through path and the divide-by-three path. Directed frames pin the word-count extremes, where the reciprocal divide is most likely to round wrongly. They also pair each enable bit alone, to tell AND from OR. Repeated frames with only the modulo or border changed confirm that the change pulse depends on geometry alone. Register changes made between ticks confirm that outputs update only at frame boundaries.

// File: rtl/disp_fmt_pkg.sv
package disp_fmt_pkg;
    localparam int FIELD_W  = 10;
    localparam int MODE_W   = 2;
    localparam int BORDER_W = 24;
    localparam int WORDS_W  = FIELD_W + 1;
    localparam int RES_W    = FIELD_W + 2;
    localparam int STRIDE_W = FIELD_W + 4;

    localparam int WPL_LSB  = 0;
    localparam int LPF_LSB  = FIELD_W;
    localparam int MOD_LSB  = 2 * FIELD_W;

    localparam int EN_BIT     = 0;
    localparam int MODE_LSB   = 2;
    localparam int VOUT_BIT   = 3;
    localparam int ILACE_BIT  = 4;
    localparam int BLANK_BIT  = 3;

    typedef struct packed {
        logic [RES_W-1:0]    hres;
        logic [RES_W-1:0]    vres;
        logic [MODE_W-1:0]   fmt;
        logic [STRIDE_W-1:0] stride;
        logic                en;
        logic                blank;
        logic [BORDER_W-1:0] border;
        logic                chg;
    } fmt_state_t;
endpackage

// File: rtl/fmt_div3.sv
module fmt_div3 #(
    parameter int W = 13
) (
    input  logic [W-1:0] num,
    output logic [W-1:0] quo
);
    localparam int SHIFT = 2 * W;
    localparam longint unsigned MAGIC = ((64'd1 << SHIFT) + 64'd2) / 64'd3;
    localparam int PROD_W = 3 * W + 1;

    logic [PROD_W-1:0] prod;

    always_comb begin
        prod = PROD_W'(num) * PROD_W'(MAGIC);
        quo  = W'(prod >> SHIFT);
    end
endmodule

// File: rtl/fmt_decode.sv
module fmt_decode
    import disp_fmt_pkg::*;
(
    input  logic [31:0]         size_word,
    input  logic [31:0]         mode_word,
    input  logic [31:0]         cfg_word,
    input  logic [31:0]         cfg2_word,
    output logic [RES_W-1:0]    hres,
    output logic [RES_W-1:0]    vres,
    output logic [MODE_W-1:0]   mode,
    output logic [STRIDE_W-1:0] stride,
    output logic                en,
    output logic                blank_req
);
    localparam int QW = RES_W + 1;

    logic [FIELD_W-1:0] wpl_f, lpf_f, mod_f;
    logic [WORDS_W-1:0] words;
    logic [RES_W-1:0]   lines;
    logic [QW-1:0]      quad, third;

    fmt_div3 #(.W(QW)) u_div3 (.num(quad), .quo(third));

    always_comb begin
        wpl_f     = size_word[WPL_LSB +: FIELD_W];
        lpf_f     = size_word[LPF_LSB +: FIELD_W];
        mod_f     = size_word[MOD_LSB +: FIELD_W];
        mode      = mode_word[MODE_LSB +: MODE_W];
        en        = mode_word[EN_BIT] & cfg_word[VOUT_BIT];
        blank_req = cfg2_word[BLANK_BIT];

        words = WORDS_W'(wpl_f) + WORDS_W'(1);
        quad  = QW'(words) << 2;
        lines = RES_W'(lpf_f) + RES_W'(1);
        vres  = cfg_word[ILACE_BIT] ? (lines << 1) : lines;

        // (words + mod - 1) * 4 == (wpl_f + mod_f) * 4
        stride = (STRIDE_W'(wpl_f) + STRIDE_W'(mod_f)) << 2;

        case (mode)
            2'd0, 2'd1: hres = RES_W'(words) << 1;
            2'd2:       hres = RES_W'(third);
            default:    hres = RES_W'(words);
        endcase
    end
endmodule

// File: rtl/disp_fmt_resolver.sv
module disp_fmt_resolver
    import disp_fmt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_tick,
    input  logic [31:0]         size_word,
    input  logic [31:0]         mode_word,
    input  logic [31:0]         cfg_word,
    input  logic [31:0]         cfg2_word,
    input  logic [BORDER_W-1:0] border_word,
    output logic [RES_W-1:0]    hres,
    output logic [RES_W-1:0]    vres,
    output logic [MODE_W-1:0]   fmt,
    output logic [STRIDE_W-1:0] stride,
    output logic                enabled,
    output logic                blank,
    output logic [BORDER_W-1:0] border,
    output logic                fmt_changed
);
    fmt_state_t st_d, st_q;

    logic [RES_W-1:0]    dec_hres, dec_vres;
    logic [MODE_W-1:0]   dec_mode;
    logic [STRIDE_W-1:0] dec_stride;
    logic                dec_en, dec_blank;

    fmt_decode u_dec (
        .size_word (size_word),
        .mode_word (mode_word),
        .cfg_word  (cfg_word),
        .cfg2_word (cfg2_word),
        .hres      (dec_hres),
        .vres      (dec_vres),
        .mode      (dec_mode),
        .stride    (dec_stride),
        .en        (dec_en),
        .blank_req (dec_blank)
    );

    always_comb begin
        st_d     = st_q;
        st_d.chg = 1'b0;
        if (frame_tick) begin
            if (dec_en) begin
                st_d.chg    = (dec_hres != st_q.hres) || (dec_vres != st_q.vres)
                           || (dec_mode != st_q.fmt);
                st_d.hres   = dec_hres;
                st_d.vres   = dec_vres;
                st_d.fmt    = dec_mode;
                st_d.stride = dec_stride;
                st_d.en     = 1'b1;
                st_d.blank  = dec_blank;
                st_d.border = dec_blank ? border_word : '0;
            end else begin
                st_d.hres   = '0;
                st_d.vres   = '0;
                st_d.en     = 1'b0;
                st_d.blank  = 1'b0;
                st_d.border = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hres        = st_q.hres;
    assign vres        = st_q.vres;
    assign fmt         = st_q.fmt;
    assign stride      = st_q.stride;
    assign enabled     = st_q.en;
    assign blank       = st_q.blank;
    assign border      = st_q.border;
    assign fmt_changed = st_q.chg;
endmodule

// File: rtl/disp_fmt_resolver_chk.sv
module disp_fmt_resolver_chk
    import disp_fmt_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                frame_tick,
    input logic [RES_W-1:0]    hres,
    input logic [RES_W-1:0]    vres,
    input logic [MODE_W-1:0]   fmt,
    input logic [STRIDE_W-1:0] stride,
    input logic                enabled,
    input logic                blank,
    input logic                fmt_changed
);
    assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_tick) |-> ($stable(hres) && $stable(vres) && $stable(fmt) && $stable(stride)));

    assert_pulse_after_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_changed |-> $past(frame_tick));

    assert_pulse_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_changed |-> enabled);

    assert_disabled_zero_res_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |-> (hres == '0 && vres == '0));

    assert_blank_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> enabled);
endmodule

bind disp_fmt_resolver disp_fmt_resolver_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_tick  (frame_tick),
    .hres        (hres),
    .vres        (vres),
    .fmt         (fmt),
    .stride      (stride),
    .enabled     (enabled),
    .blank       (blank),
    .fmt_changed (fmt_changed)
);

// File: tb/sim_disp_fmt_resolver.sv
module sim_disp_fmt_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_tick = 1'b0;
    logic [31:0] size_word = '0, mode_word = '0, cfg_word = '0, cfg2_word = '0;
    logic [23:0] border_word = '0;
    logic [11:0] hres, vres;
    logic [1:0]  fmt;
    logic [13:0] stride;
    logic        enabled, blank, fmt_changed;
    logic [23:0] border;

    int n_tests = 0, n_fail = 0;
    int e_h = 0, e_v = 0, e_f = 0, e_s = 0, e_en = 0, e_bl = 0, e_bd = 0, e_chg = 0;
    int p_h = 0, p_v = 0, p_f = 0;

    always #10 clk = ~clk;

    disp_fmt_resolver u0 (.*);

    initial begin
        #4_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_hres(input int w, input int m);
        int words = w + 1;
        case (m)
            0, 1: return words * 2;
            2:    return (words * 4) / 3;
            default: return words;
        endcase
    endfunction

    task automatic set_regs(input int w, input int l, input int md, input int m,
                            input bit den, input bit vout, input bit il,
                            input bit bl, input int bc);
        size_word   = (32'(md) << 20) | (32'(l) << 10) | 32'(w);
        mode_word   = (32'(m) << 2) | 32'(den);
        cfg_word    = (32'(il) << 4) | (32'(vout) << 3);
        cfg2_word   = 32'(bl) << 3;
        border_word = 24'(bc);
    endtask

    task automatic frame(input int w, input int l, input int md, input int m,
                         input bit den, input bit vout, input bit il,
                         input bit bl, input int bc);
        @(negedge clk);
        set_regs(w, l, md, m, den, vout, il, bl, bc);
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
        if (den && vout) begin
            e_h = exp_hres(w, m);
            e_v = (l + 1) * (il ? 2 : 1);
            e_f = m; e_s = (w + md) * 4; e_en = 1;
            e_bl = bl; e_bd = bl ? bc : 0;
            e_chg = (e_h != p_h || e_v != p_v || e_f != p_f) ? 1 : 0;
        end else begin
            e_h = 0; e_v = 0; e_en = 0; e_bl = 0; e_bd = 0; e_chg = 0;
        end
        p_h = e_h; p_v = e_v; p_f = e_f;
        chk("R4/R5 hres", int'(hres), e_h);
        chk("R3 vres", int'(vres), e_v);
        chk("R5 fmt", int'(fmt), e_f);
        chk("R6 stride", int'(stride), e_s);
        chk("R7 enabled", int'(enabled), e_en);
        chk("R8 blank", int'(blank), e_bl);
        chk("R8 border", int'(border), e_bd);
        chk("R10 fmt_changed", int'(fmt_changed), e_chg);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 hres", int'(hres), 0);
        chk("R1 vres", int'(vres), 0);
        chk("R1 stride", int'(stride), 0);
        chk("R1 enabled", int'(enabled), 0);
        chk("R1 fmt_changed", int'(fmt_changed), 0);
        rst_n = 1'b1;

        // Directed: word-count extremes through the divide by three (R5)
        frame(1023, 479, 1, 2, 1, 1, 0, 0, 0);
        frame(0, 479, 1, 2, 1, 1, 0, 0, 0);
        frame(2, 239, 1, 2, 1, 1, 1, 0, 0);
        // R10 pulse lasts one cycle
        @(negedge clk);
        chk("R10 pulse width", int'(fmt_changed), 0);
        // R11: only modulo/border/blank change
        frame(159, 479, 1, 3, 1, 1, 0, 0, 0);
        frame(159, 479, 7, 3, 1, 1, 0, 1, 24'h12_34_56);
        chk("R11 no pulse", int'(fmt_changed), 0);
        // R7: each enable bit alone
        frame(159, 479, 1, 3, 1, 0, 0, 0, 0);
        frame(159, 479, 1, 3, 0, 1, 0, 0, 0);
        chk("R9 res cleared", int'(hres), 0);
        // R9: re-enable after disable raises pulse
        frame(159, 479, 1, 3, 1, 1, 0, 0, 0);
        chk("R9 pulse after reenable", int'(fmt_changed), 1);
        // R4: modes 0 and 1
        frame(319, 239, 0, 0, 1, 1, 1, 0, 0);
        frame(319, 239, 0, 1, 1, 1, 1, 0, 0);

        // R2: register changes between ticks are ignored
        @(negedge clk);
        set_regs(5, 5, 5, 2, 1, 1, 0, 1, 24'hABCDEF);
        repeat (3) @(negedge clk);
        chk("R2 hres held", int'(hres), e_h);
        chk("R2 stride held", int'(stride), e_s);
        chk("R2 blank held", int'(blank), e_bl);

        // Random frames
        for (int i = 0; i < 400; i++) begin
            int r = int'($urandom_range(0, 9));
            frame(int'($urandom_range(0, 1023)), int'($urandom_range(0, 1023)),
                  int'($urandom_range(0, 1023)), int'($urandom_range(0, 3)),
                  r != 0, r != 1, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  int'($urandom_range(0, 24'hFFFFFF)));
            if (r == 9)
                frame(int'(size_word[9:0]), int'(size_word[19:10]), 3, int'(mode_word[3:2]),
                      1, 1, cfg_word[4], 0, 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule